// File: doc/BRIEF.md
# Self-Polling Receiver Power Sequencer

This block sets the power rhythm of a low-rate radio receiver. It moves the receiver's signal path through a repeating loop. First comes a sleep interval, with the analog path switched off. Next is a start-up interval, in which the path is powered and allowed to settle. Last is a bit-check window, in which an external timing checker judges the incoming edges. A failed check sends the receiver back to sleep. A passed check latches it into a receiving state, where it stays until an OFF command arrives.

All timing comes from a base tick, which is the crystal clock divided by 10 or 14 according to a mode pin. The sleep length is a 5-bit code multiplied by an extension factor and by a fixed number of base ticks per code step. The extension factor is either 1 or 8. The factor of 8 can be held permanently, or it can be a temporary setting that drops back to 1 after the first failed check, which saves power while a disturber keeps failing the check. Two sleep codes have special meanings: one polls without sleeping, and the other keeps the receiver asleep until the code is rewritten. An enable pin can hold the whole sequence in sleep.

Top module: `rx_poll_seq`

## Requirements
- R1: While reset is asserted, and after it is released, the state is sleep and all three outputs are low. The sleep code resets to 11 and the extension code to 00. With enable high, the first rise of `path_en` comes 11 × SLEEP_UNIT base ticks after reset is released.
- R2: The base tick period is 10 `clk` cycles when `mode_sel` is 0 and 14 cycles when it is 1. The divider restarts from zero each time the state changes.
- R3: A sleep interval lasts sleep code × factor × SLEEP_UNIT base ticks, counted from the first cycle in sleep. Then the state moves to start-up.
- R4: Sleep code 0 keeps the sleep state for exactly one clock cycle, after which start-up follows.
- R5: While the sleep code is 31, the receiver stays asleep. Once a different code is written, a full sleep interval for the new code runs, counted from the cycle after the write.
- R6: The extension code sets the factor: 00 gives a factor of 1, 01 gives a temporary 8, and 10 or 11 give a permanent 8. `cfg_wr` loads `sleep_code` and `ext_code`.
- R7: A failed bit check clears bit 0 of the stored extension code. With the temporary setting, the sleep that follows the failure already uses a factor of 1. A permanent setting is not affected.
- R8: Start-up lasts a number of base ticks chosen by `baud_sel`: 0 gives 8, 1 gives 6, 2 gives 4 and 3 gives 3. After start-up the state moves to bit check.
- R9: `path_en` is high in start-up, bit check and receiving, and low in sleep. `chk_en` is high only in bit check. In bit check, `chk_fail` leads to sleep and `chk_pass` alone leads to receiving. When both are high, fail wins.
- R10: Receiving is held until `off_cmd` is high. The next clock edge then enters sleep, and a full sleep interval follows.
- R11: When `enable` is low, the state is forced to sleep on the next clock and held there. After `enable` returns high, a full sleep interval elapses before start-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_sel | input | 1 | Base tick divider select: 0 divides by 10, 1 divides by 14 |
| baud_sel | input | 2 | Baud range, which selects the start-up length |
| cfg_wr | input | 1 | Loads sleep_code and ext_code |
| sleep_code | input | 5 | Sleep length code |
| ext_code | input | 2 | Sleep extension code |
| enable | input | 1 | Polling enable; low forces sleep |
| chk_pass | input | 1 | Bit-check pass strobe |
| chk_fail | input | 1 | Bit-check fail strobe |
| off_cmd | input | 1 | OFF command strobe, acted on in receiving |
| path_en | output | 1 | Signal-path power enable |
| chk_en | output | 1 | Bit-check window enable |
| rx_active | output | 1 | Receiving state flag |

## Verification
The hardest state to observe is the self-cleared temporary extension bit. It is stored internally, so it shows only in the length of a later sleep interval. The stimulus therefore writes the temporary code, enters sleep once through a passed check followed by OFF (expecting the long sleep), then fails a check and expects the short sleep. Random rounds repeat this with random codes, dividers and baud ranges, and a bench model tracks the stored extension code to predict every interval. The permanent-sleep code is held for thousands of cycles before it is rewritten.

// File: rtl/rx_poll_seq.sv
module rx_poll_seq #(
  parameter int DIV_LO     = 10,
  parameter int DIV_HI     = 14,
  parameter int SLEEP_UNIT = 1024,
  parameter int EXT_MULT   = 8,
  parameter int SU_B0      = 8,
  parameter int SU_B1      = 6,
  parameter int SU_B2      = 4,
  parameter int SU_B3      = 3,
  parameter logic [4:0] SLEEP_RST = 5'd11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_sel,
  input  logic [1:0] baud_sel,
  input  logic       cfg_wr,
  input  logic [4:0] sleep_code,
  input  logic [1:0] ext_code,
  input  logic       enable,
  input  logic       chk_pass,
  input  logic       chk_fail,
  input  logic       off_cmd,
  output logic       path_en,
  output logic       chk_en,
  output logic       rx_active
);

  localparam int DMAX = (DIV_LO > DIV_HI) ? DIV_LO : DIV_HI;
  localparam int DW   = $clog2(DMAX + 1);
  localparam int TW   = $clog2(31 * EXT_MULT * SLEEP_UNIT + 1);
  localparam logic [DW-1:0] DLO_M1 = DW'(DIV_LO - 1);
  localparam logic [DW-1:0] DHI_M1 = DW'(DIV_HI - 1);
  localparam logic [4:0] PERM = 5'd31;

  typedef enum logic [1:0] {S_SLEEP, S_START, S_CHECK, S_RX} st_t;

  st_t            st, nxt;
  logic [DW-1:0]  dv;
  logic [TW-1:0]  tc, target, su_len;
  logic [TW:0]    tc_inc;
  logic [4:0]     sleep_q;
  logic [1:0]     ext_q;
  logic           tick, clr, sleep_done, start_done, counting;

  assign tick     = dv >= (mode_sel ? DHI_M1 : DLO_M1);
  assign tc_inc   = {1'b0, tc} + (TW+1)'(1);
  assign target   = TW'(sleep_q) * ((ext_q != 2'b00) ? TW'(EXT_MULT) : TW'(1)) * TW'(SLEEP_UNIT);
  assign counting = (st == S_SLEEP) || (st == S_START);

  always_comb begin
    case (baud_sel)
      2'd0:    su_len = TW'(SU_B0);
      2'd1:    su_len = TW'(SU_B1);
      2'd2:    su_len = TW'(SU_B2);
      default: su_len = TW'(SU_B3);
    endcase
  end

  assign sleep_done = (sleep_q == 5'd0) ||
                      ((sleep_q != PERM) && tick && (tc_inc >= {1'b0, target}));
  assign start_done = tick && (tc_inc >= {1'b0, su_len});

  always_comb begin
    nxt = st;
    case (st)
      S_SLEEP: if (sleep_done) nxt = S_START;
      S_START: if (start_done) nxt = S_CHECK;
      S_CHECK: if (chk_fail) nxt = S_SLEEP;
               else if (chk_pass) nxt = S_RX;
      default: if (off_cmd) nxt = S_SLEEP;
    endcase
    if (!enable) nxt = S_SLEEP;
  end

  assign clr = (nxt != st) || !enable || !counting ||
               ((st == S_SLEEP) && (sleep_q == PERM));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_SLEEP;
      dv <= '0;
      tc <= '0;
    end else begin
      st <= nxt;
      if (clr) begin
        dv <= '0;
        tc <= '0;
      end else if (tick) begin
        dv <= '0;
        tc <= tc_inc[TW-1:0];
      end else begin
        dv <= dv + DW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleep_q <= SLEEP_RST;
      ext_q   <= 2'b00;
    end else if (cfg_wr) begin
      sleep_q <= sleep_code;
      ext_q   <= ext_code;
    end else if ((st == S_CHECK) && chk_fail) begin
      ext_q[0] <= 1'b0;
    end
  end

  assign path_en   = (st != S_SLEEP);
  assign chk_en    = (st == S_CHECK);
  assign rx_active = (st == S_RX);

  p_force_sleep_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (st == S_SLEEP));
  p_fail_to_sleep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CHECK) && chk_fail |=> (st == S_SLEEP));
  p_pass_to_rx_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CHECK) && chk_pass && !chk_fail && enable |=> rx_active);
  p_check_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chk_en) |-> ($past(st) == S_START));
  p_rx_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_active && !off_cmd && enable |=> rx_active);
  p_off_sleep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_active && off_cmd |=> !path_en);
  p_perm_sleep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SLEEP) && (sleep_q == PERM) && !cfg_wr |=> (st == S_SLEEP));
  p_zero_sleep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SLEEP) && (sleep_q == 5'd0) && enable |=> (st == S_START));
  p_temp_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CHECK) && chk_fail && !cfg_wr |=> !ext_q[0]);
  p_perm_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ext_q[1] && !cfg_wr |=> ext_q[1]);

endmodule

// File: tb/test_rx_poll_seq.sv
module test_rx_poll_seq;
  localparam int CLK_NS = 10;
  localparam int UNIT   = 4;

  logic clk = 1'b0;
  logic rst_n, mode_sel, cfg_wr, enable, chk_pass, chk_fail, off_cmd;
  logic [1:0] baud_sel, ext_code;
  logic [4:0] sleep_code;
  logic path_en, chk_en, rx_active;

  int checks = 0;
  int errors = 0;

  always #(CLK_NS/2) clk = ~clk;

  rx_poll_seq #(.SLEEP_UNIT(UNIT)) i_rx_poll_seq (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .baud_sel(baud_sel),
    .cfg_wr(cfg_wr), .sleep_code(sleep_code), .ext_code(ext_code),
    .enable(enable), .chk_pass(chk_pass), .chk_fail(chk_fail), .off_cmd(off_cmd),
    .path_en(path_en), .chk_en(chk_en), .rx_active(rx_active));

  function automatic int sleep_cyc(int code, logic [1:0] ext, logic md);
    if (code == 0) return 1;
    return code * ((ext != 2'b00) ? 8 : 1) * UNIT * (md ? 14 : 10);
  endfunction

  function automatic int su_cyc(logic [1:0] b, logic md);
    int s;
    case (b)
      2'd0: s = 8;
      2'd1: s = 6;
      2'd2: s = 4;
      default: s = 3;
    endcase
    return s * (md ? 14 : 10);
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_hi(input bit use_chk, input int lim, output int n);
    n = 0;
    while (n < lim) begin
      @(negedge clk);
      n++;
      chk_pass = 1'b0; chk_fail = 1'b0; off_cmd = 1'b0; cfg_wr = 1'b0;
      if ((use_chk ? chk_en : path_en) == 1'b1) break;
    end
  endtask

  task automatic write_cfg(int code, logic [1:0] ext);
    sleep_code = 5'(code); ext_code = ext; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic startup(string tag);
    int n;
    wait_hi(1'b1, 5000, n);
    check(tag, n, su_cyc(baud_sel, mode_sel));
  endtask

  initial begin
    int n;
    int code;
    logic [1:0] ext_m;
    void'($urandom(32'd4242));
    rst_n = 1'b0; mode_sel = 1'b0; baud_sel = 2'd0; cfg_wr = 1'b0;
    sleep_code = '0; ext_code = '0; enable = 1'b1;
    chk_pass = 1'b0; chk_fail = 1'b0; off_cmd = 1'b0;
    repeat (5) @(negedge clk);
    check("R1 reset path_en", path_en, 0);
    check("R1 reset chk_en", chk_en, 0);
    check("R1 reset rx_active", rx_active, 0);
    rst_n = 1'b1;
    wait_hi(1'b0, 5000, n);
    check("R1 R3 default sleep", n, sleep_cyc(11, 2'b00, 1'b0));
    check("R9 chk_en low in start-up", chk_en, 0);
    startup("R8 start-up baud0");
    ext_m = 2'b00;

    chk_pass = 1'b1; chk_fail = 1'b1;
    wait_hi(1'b0, 5000, n);
    check("R9 fail wins over pass", n, 1 + sleep_cyc(11, ext_m, 1'b0));
    startup("R8 start-up after fail");

    write_cfg(0, 2'b00);
    chk_fail = 1'b1;
    wait_hi(1'b0, 100, n);
    check("R4 code zero sleep", n, 2);
    startup("R4 start-up after zero sleep");

    chk_pass = 1'b1;
    @(negedge clk); chk_pass = 1'b0;
    check("R9 pass enters receiving", rx_active, 1);
    check("R9 chk_en low in receiving", chk_en, 0);
    n = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (rx_active) n++;
    end
    check("R10 receiving held", n, 50);
    write_cfg(1, 2'b10);
    check("R10 cfg write keeps receiving", rx_active, 1);
    off_cmd = 1'b1;
    wait_hi(1'b0, 5000, n);
    check("R6 R10 permanent x8 after off", n, 1 + sleep_cyc(1, 2'b10, 1'b0));
    startup("R8 start-up");
    chk_fail = 1'b1;
    wait_hi(1'b0, 5000, n);
    check("R7 permanent factor kept after fail", n, 1 + sleep_cyc(1, 2'b10, 1'b0));
    startup("R8 start-up");

    write_cfg(1, 2'b01);
    chk_pass = 1'b1;
    @(negedge clk); chk_pass = 1'b0;
    off_cmd = 1'b1;
    wait_hi(1'b0, 5000, n);
    check("R6 temporary x8 before fail", n, 1 + sleep_cyc(1, 2'b01, 1'b0));
    startup("R8 start-up");
    chk_fail = 1'b1;
    wait_hi(1'b0, 5000, n);
    check("R7 temporary cleared by fail", n, 1 + sleep_cyc(1, 2'b00, 1'b0));
    startup("R8 start-up");
    chk_fail = 1'b1;
    wait_hi(1'b0, 5000, n);
    check("R7 temporary stays cleared", n, 1 + sleep_cyc(1, 2'b00, 1'b0));
    startup("R8 start-up");

    write_cfg(2, 2'b00);
    mode_sel = 1'b1;
    for (int b = 0; b < 4; b++) begin
      baud_sel = 2'(b);
      chk_fail = 1'b1;
      wait_hi(1'b0, 5000, n);
      check("R2 divide by 14 sleep", n, 1 + sleep_cyc(2, 2'b00, 1'b1));
      startup("R8 R2 start-up per baud range");
    end
    baud_sel = 2'd0;

    write_cfg(31, 2'b00);
    chk_fail = 1'b1;
    wait_hi(1'b0, 3000, n);
    check("R5 permanent sleep holds", n, 3000);
    check("R5 path_en low in permanent sleep", path_en, 0);
    sleep_code = 5'd1; ext_code = 2'b00; cfg_wr = 1'b1;
    wait_hi(1'b0, 5000, n);
    check("R5 sleep after rewrite", n, 1 + sleep_cyc(1, 2'b00, 1'b1));
    startup("R8 start-up");

    enable = 1'b0; chk_pass = 1'b1;
    @(negedge clk); chk_pass = 1'b0;
    check("R11 enable low forces sleep", path_en, 0);
    check("R11 pass ignored while disabled", rx_active, 0);
    n = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (path_en) n++;
    end
    check("R11 held asleep", n, 0);
    enable = 1'b1;
    wait_hi(1'b0, 5000, n);
    check("R11 full sleep after enable", n, sleep_cyc(1, 2'b00, 1'b1));
    startup("R8 start-up");
    chk_pass = 1'b1;
    @(negedge clk); chk_pass = 1'b0;
    enable = 1'b0;
    @(negedge clk);
    check("R11 enable low leaves receiving", rx_active, 0);
    check("R11 path off from receiving", path_en, 0);
    enable = 1'b1;
    wait_hi(1'b0, 5000, n);
    startup("R8 start-up");

    for (int it = 0; it < 25; it++) begin
      code = $urandom_range(0, 6);
      ext_m = 2'($urandom_range(0, 3));
      mode_sel = 1'($urandom_range(0, 1));
      baud_sel = 2'($urandom_range(0, 3));
      write_cfg(code, ext_m);
      if ($urandom_range(0, 1) == 0) begin
        chk_fail = 1'b1;
        ext_m[0] = 1'b0;
        wait_hi(1'b0, 20000, n);
        check("R3 R7 random sleep after fail", n, 1 + sleep_cyc(code, ext_m, mode_sel));
      end else begin
        chk_pass = 1'b1;
        @(negedge clk); chk_pass = 1'b0;
        check("R9 random pass", rx_active, 1);
        repeat ($urandom_range(1, 20)) @(negedge clk);
        check("R10 random hold", rx_active, 1);
        off_cmd = 1'b1;
        wait_hi(1'b0, 20000, n);
        check("R3 R6 random sleep after off", n, 1 + sleep_cyc(code, ext_m, mode_sel));
      end
      startup("R8 R2 random start-up");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule